// File: doc/BRIEF.md
# Lockdown-aware memory protection permission gate

This block makes the final allow/deny decision for a single memory access. It takes the configuration byte of the protection entry that an upstream matcher has already chosen as the highest-priority hit, or a flag saying that no entry matched. It combines that byte with the access kind, the current privilege level and two policy bits from the security configuration register. Address comparison, priority selection and fault-cause encoding happen elsewhere. The result is one grant flag, registered on the clock edge that follows the inputs.

There are two policy bits. The lockdown bit changes what the entry's lock bit means. Without lockdown, the lock bit only forces machine mode to obey the entry's permissions. With lockdown, it marks a region as belonging to machine mode or to the lower modes. Some otherwise reserved read/write/execute combinations then become regions shared between machine mode and the lower modes. The whitelist bit makes machine-mode accesses that match no entry fail. The parameter `ENHANCED` set to 0 builds the legacy checker, in which both policy bits are taken as zero.

Top module: `pmp_perm_gate`

## Requirements
- R1: `grant_q` is a register with a synchronous active-high reset. While `rst` is high at a clock edge it becomes 0. Otherwise each edge loads the decision for the inputs present at that edge, so the result appears one cycle after the inputs.
- R2: `entry_cfg` bit positions are: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 address mode, bit 7 lock. Bits 6:5 and 4:3 never affect the decision.
- R3: Access code 00 is a read, 01 a write and 10 an execute. Privilege code 11 is machine, 01 supervisor and 00 user. Access code 11 is always denied.
- R4: With lockdown off and a matching entry, a machine access to an entry with lock clear is granted. A machine access to a locked entry, and any supervisor or user access, is granted only when the entry's permission bit for that access kind is set.
- R5: With lockdown on and an entry having lock=1, read=0, write=1: execute is granted in every mode. A read is granted only in machine mode with execute=1. A write is always denied.
- R6: With lockdown on and an entry having lock=0, read=0, write=1: a read is granted in every mode. A write is granted in machine mode, or in any mode when execute=1. Execute is denied.
- R7: With lockdown on and an entry having lock, read, write and execute all set, only reads are granted, in every mode.
- R8: With lockdown on and any other entry encoding, the access is checked against the permission bits when machine mode and the lock bit agree (machine with lock=1, or non-machine with lock=0). Otherwise it is denied.
- R9: With no matching entry, a supervisor or user access is denied.
- R10: With no matching entry in machine mode, everything is denied when the whitelist bit is set. Otherwise, with lockdown on, only execute is denied. Otherwise the access is granted.
- R11: With `ENHANCED`=0, the lockdown and whitelist inputs have no effect. The decision equals the one made with both bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_vld | input | 1 | An entry matched the access |
| entry_cfg | input | 8 | Configuration byte of the matched entry |
| acc_kind | input | 2 | Access kind code |
| priv_lvl | input | 2 | Current privilege code |
| lockdown | input | 1 | Machine-mode lockdown policy bit |
| strict_miss | input | 1 | Deny machine accesses that match no entry |
| grant_q | output | 1 | Registered grant decision |

## Verification
The assertions take `acc_kind` and `priv_lvl` to carry only the defined codes, with the privilege never at the reserved value 10. A check whose premise names an access kind or privilege is meaningless outside those codes. The stimulus walks only the three privilege codes. It sweeps every value of the configuration byte under all four policy settings and all four access codes, including the always-denied code 11. Inputs change only at falling edges, so every clock edge sees one settled combination.

// File: rtl/pmp_perm_pkg.sv
package pmp_perm_pkg;
  localparam int CFG_W  = 8;
  localparam int ACC_W  = 2;
  localparam int PRIV_W = 2;

  typedef enum logic [ACC_W-1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_BAD   = 2'b11
  } acc_e;

  localparam logic [PRIV_W-1:0] PRV_USER  = 2'b00;
  localparam logic [PRIV_W-1:0] PRV_SUPER = 2'b01;
  localparam logic [PRIV_W-1:0] PRV_MACH  = 2'b11;

  typedef struct packed {
    logic       lk;
    logic [1:0] rsv;
    logic [1:0] mode;
    logic       x;
    logic       w;
    logic       r;
  } cfg_t;
endpackage

// File: rtl/pmp_hit_rules.sv
module pmp_hit_rules
  import pmp_perm_pkg::*;
(
  input  cfg_t             cfg,
  input  logic [ACC_W-1:0] acc,
  input  logic             is_mach,
  input  logic             lockdown,
  output logic             ok
);
  logic is_ld, is_st, is_fx, perm_ok;

  always_comb begin
    is_ld   = (acc == ACC_LOAD);
    is_st   = (acc == ACC_STORE);
    is_fx   = (acc == ACC_FETCH);
    perm_ok = (is_ld & cfg.r) | (is_st & cfg.w) | (is_fx & cfg.x);
    if (!lockdown) begin
      ok = perm_ok | (is_mach & ~cfg.lk & (is_ld | is_st | is_fx));
    end else begin
      unique casez ({cfg.lk, cfg.r, cfg.w, cfg.x})
        4'b101?: ok = is_fx | (is_ld & is_mach & cfg.x);
        4'b001?: ok = is_ld | (is_st & (is_mach | cfg.x));
        4'b1111: ok = is_ld;
        default: ok = (is_mach == cfg.lk) & perm_ok;
      endcase
    end
  end
endmodule

// File: rtl/pmp_miss_rules.sv
module pmp_miss_rules
  import pmp_perm_pkg::*;
(
  input  logic [ACC_W-1:0] acc,
  input  logic             is_mach,
  input  logic             lockdown,
  input  logic             strict_miss,
  output logic             ok
);
  logic known;

  always_comb begin
    known = (acc != ACC_BAD);
    ok    = known & is_mach & ~strict_miss & ~(lockdown & (acc == ACC_FETCH));
  end
endmodule

// File: rtl/pmp_perm_gate.sv
module pmp_perm_gate
  import pmp_perm_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              match_vld,
  input  logic [CFG_W-1:0]  entry_cfg,
  input  logic [ACC_W-1:0]  acc_kind,
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic              lockdown,
  input  logic              strict_miss,
  output logic              grant_q
);
  logic eff_lock, eff_strict, is_mach, hit_ok, miss_ok, grant_d;
  cfg_t cfg_s;

  generate
    if (ENHANCED) begin : g_enh
      assign eff_lock   = lockdown;
      assign eff_strict = strict_miss;
    end else begin : g_legacy
      assign eff_lock   = 1'b0;
      assign eff_strict = 1'b0;
    end
  endgenerate

  assign cfg_s   = cfg_t'(entry_cfg);
  assign is_mach = (priv_lvl == PRV_MACH);

  pmp_hit_rules u_hit (
    .cfg      (cfg_s),
    .acc      (acc_kind),
    .is_mach  (is_mach),
    .lockdown (eff_lock),
    .ok       (hit_ok)
  );

  pmp_miss_rules u_miss (
    .acc         (acc_kind),
    .is_mach     (is_mach),
    .lockdown    (eff_lock),
    .strict_miss (eff_strict),
    .ok          (miss_ok)
  );

  assign grant_d = match_vld ? hit_ok : miss_ok;

  always_ff @(posedge clk) begin
    if (rst) grant_q <= 1'b0;
    else     grant_q <= grant_d;
  end
endmodule

// File: rtl/pmp_perm_chk.sv
module pmp_perm_chk #(
  parameter bit ENHANCED = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       match_vld,
  input logic [7:0] entry_cfg,
  input logic [1:0] acc_kind,
  input logic [1:0] priv_lvl,
  input logic       lockdown,
  input logic       strict_miss,
  input logic       grant_q
);
  logic ld_on;
  assign ld_on = ENHANCED & lockdown;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !grant_q);

  assert_miss_lowpriv_denied_R9: assert property (@(posedge clk) disable iff (rst)
    (!match_vld && priv_lvl != 2'b11) |=> !grant_q);

  assert_miss_strict_denied_R10: assert property (@(posedge clk) disable iff (rst)
    (ENHANCED && !match_vld && strict_miss) |=> !grant_q);

  assert_legacy_mach_unlocked_R4: assert property (@(posedge clk) disable iff (rst)
    (match_vld && !ld_on && priv_lvl == 2'b11 && !entry_cfg[7] && acc_kind != 2'b11)
      |=> grant_q);

  assert_exec_only_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (match_vld && ld_on && entry_cfg[7] && !entry_cfg[0] && entry_cfg[1] && acc_kind == 2'b01)
      |=> !grant_q);

  assert_shared_ro_R7: assert property (@(posedge clk) disable iff (rst)
    (match_vld && ld_on && entry_cfg[7] && entry_cfg[2:0] == 3'b111 && acc_kind != 2'b00)
      |=> !grant_q);

  assert_bad_code_denied_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == 2'b11) |=> !grant_q);
endmodule

bind pmp_perm_gate pmp_perm_chk #(.ENHANCED(ENHANCED)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .match_vld   (match_vld),
  .entry_cfg   (entry_cfg),
  .acc_kind    (acc_kind),
  .priv_lvl    (priv_lvl),
  .lockdown    (lockdown),
  .strict_miss (strict_miss),
  .grant_q     (grant_q)
);

// File: tb/tb_pmp_perm_gate.sv
module tb_pmp_perm_gate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       match_vld = 1'b0;
  logic [7:0] entry_cfg = '0;
  logic [1:0] acc_kind = '0;
  logic [1:0] priv_lvl = '0;
  logic       lockdown = 1'b0;
  logic       strict_miss = 1'b0;
  logic       grant_q, grant_leg;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pmp_perm_gate #(.ENHANCED(1'b1)) dut (
    .clk(clk), .rst(rst), .match_vld(match_vld), .entry_cfg(entry_cfg),
    .acc_kind(acc_kind), .priv_lvl(priv_lvl), .lockdown(lockdown),
    .strict_miss(strict_miss), .grant_q(grant_q));

  pmp_perm_gate #(.ENHANCED(1'b0)) dut_legacy (
    .clk(clk), .rst(rst), .match_vld(match_vld), .entry_cfg(entry_cfg),
    .acc_kind(acc_kind), .priv_lvl(priv_lvl), .lockdown(lockdown),
    .strict_miss(strict_miss), .grant_q(grant_leg));

  // Reference model built straight from the requirement text.
  function automatic bit expect_grant(bit mv, logic [7:0] c, logic [1:0] a,
                                      logic [1:0] p, bit ld, bit st);
    bit m, L, r, w, x, rd, wr, ex, want;
    m = (p == 2'b11); L = c[7]; r = c[0]; w = c[1]; x = c[2];
    rd = (a == 2'b00); wr = (a == 2'b01); ex = (a == 2'b10);
    want = (rd && r) || (wr && w) || (ex && x);
    if (a == 2'b11) return 1'b0;
    if (!mv) begin
      if (!m) return 1'b0;
      if (st) return 1'b0;
      if (ld && ex) return 1'b0;
      return 1'b1;
    end
    if (!ld) return (m && !L) ? 1'b1 : want;
    if (L && !r && w) return ex || (rd && m && x);
    if (!L && !r && w) return rd || (wr && (m || x));
    if (L && r && w && x) return rd;
    return (m == L) ? want : 1'b0;
  endfunction

  function automatic string tag_of(bit mv, logic [7:0] c, logic [1:0] a,
                                   logic [1:0] p, bit ld);
    if (a == 2'b11) return "R3";
    if (!mv) return (p == 2'b11) ? "R10" : "R9";
    if (!ld) return "R4";
    if (c[7] && !c[0] && c[1]) return "R5";
    if (!c[7] && !c[0] && c[1]) return "R6";
    if (c[7] && c[2:0] == 3'b111) return "R7";
    return "R8";
  endfunction

  task automatic step(bit mv, logic [7:0] c, logic [1:0] a, logic [1:0] p, bit ld, bit st);
    bit e_enh, e_leg;
    string t;
    @(negedge clk);
    match_vld = mv; entry_cfg = c; acc_kind = a; priv_lvl = p;
    lockdown = ld; strict_miss = st;
    @(posedge clk);
    #2;
    e_enh = expect_grant(mv, c, a, p, ld, st);
    e_leg = expect_grant(mv, c, a, p, 1'b0, 1'b0);
    t = tag_of(mv, c, a, p, ld);
    n_chk++;
    if (grant_q !== e_enh) begin
      n_bad++;
      $display("FAIL %s/R2 enh cfg=%h acc=%0d priv=%0d mv=%0b ld=%0b st=%0b actual=%b expected=%b",
               t, c, a, p, mv, ld, st, grant_q, e_enh);
    end
    n_chk++;
    if (grant_leg !== e_leg) begin
      n_bad++;
      $display("FAIL R11 legacy cfg=%h acc=%0d priv=%0d mv=%0b ld=%0b st=%0b actual=%b expected=%b",
               c, a, p, mv, ld, st, grant_leg, e_leg);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [1:0] privs [3];
    privs[0] = 2'b00; privs[1] = 2'b01; privs[2] = 2'b11;
    // R1: reset holds the output low even with a granting input
    match_vld = 1'b0; priv_lvl = 2'b11; acc_kind = 2'b00;
    repeat (3) @(posedge clk);
    #2;
    n_chk++;
    if (grant_q !== 1'b0 || grant_leg !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%b/%b expected=0/0", grant_q, grant_leg);
    end
    @(negedge clk); rst = 1'b0;
    // R1: one-cycle latency, then reset clears a granted output
    step(1'b0, 8'h00, 2'b00, 2'b11, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    n_chk++;
    if (grant_q !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 sync clear actual=%b expected=0", grant_q);
    end
    @(negedge clk); rst = 1'b0;
    // R2-R8, R11: every config byte, access code, privilege and policy setting
    for (int pol = 0; pol < 4; pol++)
      for (int cv = 0; cv < 256; cv++)
        for (int ai = 0; ai < 4; ai++)
          for (int pi = 0; pi < 3; pi++)
            step(1'b1, cv[7:0], ai[1:0], privs[pi], pol[0], pol[1]);
    // R9, R10: no-match cases, config byte noise must not matter
    for (int pol = 0; pol < 4; pol++)
      for (int ai = 0; ai < 4; ai++)
        for (int pi = 0; pi < 3; pi++)
          step(1'b0, 8'hA5 ^ 8'(ai * 37), ai[1:0], privs[pi], pol[0], pol[1]);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule